// File: doc/BRIEF.md
# DRAM Row Refresh Scheduler

This block keeps a dynamic memory's contents alive. An interval timer divides the refresh period into one slot per row and raises a refresh request in each slot. A small debt counter keeps requests that could not be served at once. A state machine turns each request into a strobe sequence on the memory's row strobe, column strobe and write enable lines. The sequence is either a row-address-only refresh, where the block drives the row number from its own counter, or a column-before-row refresh, where the memory picks the row and the address lines stay undriven. The `cbr_mode` input chooses the protocol for each refresh when that refresh starts.

The block also arbitrates with an access controller. A request on `acc_req` is granted only while no refresh cycle is running. The grant lasts until the request is withdrawn. While the grant is held, the block keeps its own strobes inactive, so they can be wire-ANDed with the controller's strobes. Refreshes that fall due during a long access are counted and then served back to back.

A sleep request puts the memory into self-refresh with a column-before-row entry. The row strobe is then held low for a minimum time. Wake-up raises both strobes and holds them high for one precharge time before the block accepts any other work.

The states are:
- IDLE: the arbitration point.
- ACCESS: the access controller holds the grant.
- ROR_HOLD: the row strobe is low and the row address is driven.
- CBR_LEAD, CBR_HOLD, CBR_TAIL: column low, then both low, then column high with row still low.
- PRECHARGE: both strobes high after a refresh.
- SLEEP_LEAD, SLEEP_HOLD: self-refresh entry and residence.
- WAKE: the precharge after self-refresh.

The transitions are:
- IDLE goes to ROR_HOLD or CBR_LEAD when debt is owed. Otherwise it goes to SLEEP_LEAD on a sleep request, or to ACCESS on an access request, in that priority.
- ACCESS goes to IDLE when the request drops.
- ROR_HOLD goes to PRECHARGE.
- CBR_LEAD goes to CBR_HOLD, then CBR_TAIL, then PRECHARGE.
- PRECHARGE goes to IDLE.
- SLEEP_LEAD goes to SLEEP_HOLD.
- SLEEP_HOLD goes to WAKE once the minimum time has passed and the sleep request is low.
- WAKE goes to IDLE.

Each timed state lasts a fixed number of cycles, given by a parameter.

Top module: `dram_refresh_engine`

## Requirements
- R1: While reset is asserted, and right after it is released, `ras_n`, `cas_n` and `we_n` are 1, and `addr_oe`, `acc_grant` and `ref_busy` are 0.
- R2: In an otherwise idle block, refresh sequences start exactly INTERVAL_CYC / 2^ROW_BITS cycles apart (32 with default parameters).
- R3: A row-address-only refresh works as follows. `ras_n` is 0 for RAS_LOW_CYC cycles (4) while `cas_n` stays 1 and `addr_oe` is 1. Then `ras_n` is 1 for PRECH_CYC cycles (3) while `ref_busy` is 1.
- R4: During a row-address-only refresh, `addr_o` carries the internal row counter. The counter starts at 0 after reset, advances by one after each such refresh, and wraps at 2^ROW_BITS. Column-before-row refreshes leave it unchanged.
- R5: A column-before-row refresh works as follows. `cas_n` is 0 with `ras_n` 1 for CBR_LEAD_CYC cycles (2). Then both are 0 for RAS_LOW_CYC cycles (4). Then `cas_n` is 1 with `ras_n` 0 for CBR_TAIL_CYC cycles (2). Then both are 1 for PRECH_CYC cycles (3). Throughout, `addr_oe` is 0 and `we_n` is 1.
- R6: The protocol of a refresh is set by `cbr_mode` when the refresh starts: 0 selects row-address-only and 1 selects column-before-row.
- R7: Refresh requests that cannot be served are counted up to MAX_OWED (3). Requests beyond that are dropped. Owed requests are served back to back once the block returns to IDLE.
- R8: In IDLE, an owed refresh wins over `acc_req`. `acc_grant` rises only from IDLE and stays high until `acc_req` drops. While it is high, `ras_n` and `cas_n` are 1, `ref_busy` is 0, and no refresh preempts it.
- R9: A sleep request in IDLE, with no debt, starts a CBR_LEAD_CYC column-low lead. Both strobes are then held low for at least SELF_MIN_CYC cycles (40), and for as long as `sleep_req` stays high.
- R10: On wake-up, both strobes stay high for PRECH_CYC cycles before IDLE. Debt is discarded during self-refresh and wake-up. So an access that is pending at wake-up is granted PRECH_CYC+1 cycles after `ras_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cbr_mode | input | 1 | 1 = column-before-row refresh, 0 = row-address-only refresh |
| sleep_req | input | 1 | Request to enter and stay in self-refresh |
| acc_req | input | 1 | Access controller wants the memory |
| acc_grant | output | 1 | Memory handed to the access controller |
| ref_busy | output | 1 | A refresh, sleep or wake sequence is in progress |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high (read) |
| addr_o | output | ROW_BITS | Row address for row-address-only refresh |
| addr_oe | output | 1 | Address lines driven by this block |

## Verification
The main function is exercised with a mixed sequence of row-address-only and column-before-row refreshes.
- Back-to-back row-only refreshes show whether the row counter advances and wraps.
- Column-before-row refreshes placed between them show that the counter stays untouched and that the strobe order is reversed.
- The spacing between refresh starts tells an even spread apart from bunching.

A long access followed by a one-cycle drop of the request separates debt saturation from unbounded counting, and it separates refresh priority from grant priority. Two sleep requests, one very short and one longer than the minimum, separate the minimum residence time from following the request. The grant delay after each wake shows both the precharge time and the discarding of debt.

// File: rtl/dref_pkg.sv
package dref_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ACCESS,
        ST_ROR_HOLD,
        ST_CBR_LEAD,
        ST_CBR_HOLD,
        ST_CBR_TAIL,
        ST_PRECHARGE,
        ST_SLEEP_LEAD,
        ST_SLEEP_HOLD,
        ST_WAKE
    } dref_state_e;

endpackage

// File: rtl/dref_tick.sv
// Divides the refresh interval into equal per-row slots.
module dref_tick #(
    parameter int PERIOD = 32
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/dref_owed.sv
// Saturating count of refresh slots not yet served.
module dref_owed #(
    parameter int MAX_OWED = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic take,
    input  logic clr,
    output logic pending
);
    localparam int OW = $clog2(MAX_OWED + 1);
    localparam logic [OW-1:0] FULL = OW'(MAX_OWED);

    logic [OW-1:0] cnt;
    logic          inc;

    // a tick at full is kept only if one is taken in the same cycle
    assign inc = tick && ((cnt != FULL) || take);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc && !take) begin
            cnt <= cnt + 1'b1;
        end else if (!inc && take) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign pending = (cnt != '0);
endmodule

// File: rtl/dref_row.sv
// Row pointer for refreshes that supply their own address.
module dref_row #(
    parameter int ROW_BITS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv,
    output logic [ROW_BITS-1:0] row
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row <= '0;
        end else if (adv) begin
            row <= row + 1'b1;
        end
    end
endmodule

// File: rtl/dram_refresh_engine.sv
module dram_refresh_engine
    import dref_pkg::*;
#(
    parameter int ROW_BITS     = 3,
    parameter int INTERVAL_CYC = 256,
    parameter int RAS_LOW_CYC  = 4,
    parameter int PRECH_CYC    = 3,
    parameter int CBR_LEAD_CYC = 2,
    parameter int CBR_TAIL_CYC = 2,
    parameter int SELF_MIN_CYC = 40,
    parameter int MAX_OWED     = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cbr_mode,
    input  logic                sleep_req,
    input  logic                acc_req,
    output logic                acc_grant,
    output logic                ref_busy,
    output logic                ras_n,
    output logic                cas_n,
    output logic                we_n,
    output logic [ROW_BITS-1:0] addr_o,
    output logic                addr_oe
);
    localparam int ROWS     = 1 << ROW_BITS;
    localparam int SLOT_CYC = INTERVAL_CYC / ROWS;
    localparam int M_A      = (RAS_LOW_CYC > PRECH_CYC) ? RAS_LOW_CYC : PRECH_CYC;
    localparam int M_B      = (CBR_LEAD_CYC > CBR_TAIL_CYC) ? CBR_LEAD_CYC : CBR_TAIL_CYC;
    localparam int M_AB     = (M_A > M_B) ? M_A : M_B;
    localparam int DUR_MAX  = (SELF_MIN_CYC > M_AB) ? SELF_MIN_CYC : M_AB;
    localparam int TW       = $clog2(DUR_MAX + 1);

    dref_state_e         state, nxt;
    logic [TW-1:0]       tmr;
    logic                tick, pending, take, clr_owed, row_adv, tmr_done;
    logic [ROW_BITS-1:0] row;

    dref_tick #(.PERIOD(SLOT_CYC)) tick_i (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    dref_owed #(.MAX_OWED(MAX_OWED)) owed_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .take(take),
        .clr(clr_owed), .pending(pending)
    );

    dref_row #(.ROW_BITS(ROW_BITS)) row_i (
        .clk(clk), .rst_n(rst_n), .adv(row_adv), .row(row)
    );

    assign tmr_done = (tmr == '0);
    assign take     = (state == ST_IDLE) && pending;
    assign clr_owed = (state == ST_SLEEP_HOLD) || (state == ST_WAKE);
    assign row_adv  = (state == ST_ROR_HOLD) && tmr_done;

    // residence time of a state, loaded as count-minus-one on entry
    function automatic logic [TW-1:0] dur_of(input dref_state_e s);
        unique case (s)
            ST_ROR_HOLD, ST_CBR_HOLD:   dur_of = TW'(RAS_LOW_CYC - 1);
            ST_CBR_LEAD, ST_SLEEP_LEAD: dur_of = TW'(CBR_LEAD_CYC - 1);
            ST_CBR_TAIL:                dur_of = TW'(CBR_TAIL_CYC - 1);
            ST_PRECHARGE, ST_WAKE:      dur_of = TW'(PRECH_CYC - 1);
            ST_SLEEP_HOLD:              dur_of = TW'(SELF_MIN_CYC - 1);
            ST_IDLE, ST_ACCESS:         dur_of = '0;
        endcase
    endfunction

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (pending)        nxt = cbr_mode ? ST_CBR_LEAD : ST_ROR_HOLD;
                else if (sleep_req) nxt = ST_SLEEP_LEAD;
                else if (acc_req)   nxt = ST_ACCESS;
            end
            ST_ACCESS:     if (!acc_req) nxt = ST_IDLE;
            ST_ROR_HOLD:   if (tmr_done) nxt = ST_PRECHARGE;
            ST_CBR_LEAD:   if (tmr_done) nxt = ST_CBR_HOLD;
            ST_CBR_HOLD:   if (tmr_done) nxt = ST_CBR_TAIL;
            ST_CBR_TAIL:   if (tmr_done) nxt = ST_PRECHARGE;
            ST_PRECHARGE:  if (tmr_done) nxt = ST_IDLE;
            ST_SLEEP_LEAD: if (tmr_done) nxt = ST_SLEEP_HOLD;
            ST_SLEEP_HOLD: if (tmr_done && !sleep_req) nxt = ST_WAKE;
            ST_WAKE:       if (tmr_done) nxt = ST_IDLE;
        endcase
    end

    // state register with its residence timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            tmr   <= '0;
        end else begin
            state <= nxt;
            if (nxt != state)  tmr <= dur_of(nxt);
            else if (!tmr_done) tmr <= tmr - 1'b1;
        end
    end

    // strobe and handshake outputs decoded from the state
    always_comb begin
        ras_n     = 1'b1;
        cas_n     = 1'b1;
        we_n      = 1'b1;
        addr_oe   = 1'b0;
        acc_grant = 1'b0;
        ref_busy  = 1'b1;
        unique case (state)
            ST_IDLE:   ref_busy = 1'b0;
            ST_ACCESS: begin
                ref_busy  = 1'b0;
                acc_grant = 1'b1;
            end
            ST_ROR_HOLD: begin
                ras_n   = 1'b0;
                addr_oe = 1'b1;
            end
            ST_CBR_LEAD, ST_SLEEP_LEAD: cas_n = 1'b0;
            ST_CBR_HOLD, ST_SLEEP_HOLD: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
            end
            ST_CBR_TAIL:           ras_n = 1'b0;
            ST_PRECHARGE, ST_WAKE: ras_n = 1'b1;
        endcase
        addr_o = addr_oe ? row : '0;
    end
endmodule

// File: rtl/dref_chk.sv
module dref_chk #(
    parameter int ROW_BITS    = 3,
    parameter int RAS_LOW_CYC = 4,
    parameter int PRECH_CYC   = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ras_n,
    input logic                cas_n,
    input logic                we_n,
    input logic [ROW_BITS-1:0] addr_o,
    input logic                addr_oe,
    input logic                acc_grant,
    input logic                ref_busy
);
    logic [15:0]         lo_run, hi_run;
    logic [ROW_BITS-1:0] last_row;
    logic                seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_run   <= '0;
            hi_run   <= 16'(PRECH_CYC);
            last_row <= '0;
            seen     <= 1'b0;
        end else begin
            lo_run <= ras_n ? '0 : ((lo_run == 16'hFFFF) ? lo_run : lo_run + 1'b1);
            hi_run <= !ras_n ? '0 : ((hi_run == 16'hFFFF) ? hi_run : hi_run + 1'b1);
            if (addr_oe) begin
                last_row <= addr_o;
                seen     <= 1'b1;
            end
        end
    end

    assert_grant_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_grant |-> (ras_n && cas_n && !ref_busy));

    assert_cbr_no_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> (!addr_oe && we_n));

    assert_cbr_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !cas_n) |-> $past(!cas_n));

    assert_ror_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && cas_n) |-> addr_oe);

    assert_row_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(addr_oe) && seen) |-> (addr_o == ROW_BITS'(last_row + 1'b1)));

    assert_ras_min_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n && (lo_run != '0)) |-> (lo_run >= 16'(RAS_LOW_CYC)));

    assert_precharge_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) || $rose(acc_grant)) |-> (hi_run >= 16'(PRECH_CYC)));
endmodule

bind dram_refresh_engine dref_chk #(
    .ROW_BITS(ROW_BITS), .RAS_LOW_CYC(RAS_LOW_CYC), .PRECH_CYC(PRECH_CYC)
) chk_i (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr_o(addr_o), .addr_oe(addr_oe), .acc_grant(acc_grant), .ref_busy(ref_busy)
);

// File: tb/dram_refresh_engine_tb_top.sv
module dram_refresh_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SLOT       = 32;
    localparam int RAS_LOW    = 4;
    localparam int PRECH      = 3;
    localparam int LEAD       = 2;
    localparam int TAIL       = 2;
    localparam int SELF_MIN   = 40;
    localparam int NVEC       = 11;
    // {cbr_mode, expected row}
    localparam logic [3:0] VEC [NVEC] = '{
        4'b0000, 4'b0001, 4'b1000, 4'b0010, 4'b1000, 4'b0011,
        4'b0100, 4'b0101, 4'b0110, 4'b0111, 4'b0000
    };

    logic       clk = 1'b0;
    logic       rst_n, cbr_mode, sleep_req, acc_req;
    logic       acc_grant, ref_busy, ras_n, cas_n, we_n, addr_oe;
    logic [2:0] addr_o;
    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc++;

    dram_refresh_engine dut_i (
        .clk(clk), .rst_n(rst_n), .cbr_mode(cbr_mode), .sleep_req(sleep_req),
        .acc_req(acc_req), .acc_grant(acc_grant), .ref_busy(ref_busy),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr_o(addr_o), .addr_oe(addr_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_idle_outs(input string req);
        check(ras_n && cas_n && we_n && !addr_oe && !acc_grant && !ref_busy, req,
              {ras_n, cas_n, we_n, addr_oe, acc_grant, ref_busy}, 6'b111000);
    endtask

    task automatic do_refresh(input bit cbr, input int row);
        int n;
        if (!cbr) begin
            check(cas_n && addr_oe, "R6 row-only start", {cas_n, addr_oe}, 2'b11);
            check(int'(addr_o) == row, "R4 row address", int'(addr_o), row);
            n = 0;
            while (!ras_n) begin n++; @(negedge clk); end
            check(n == RAS_LOW, "R3 ras low length", n, RAS_LOW);
        end else begin
            check(!addr_oe && we_n && ras_n, "R5 cbr start", {addr_oe, we_n, ras_n}, 3'b011);
            n = 0;
            while (!cas_n && ras_n) begin n++; @(negedge clk); end
            check(n == LEAD, "R5 cas lead", n, LEAD);
            n = 0;
            while (!cas_n && !ras_n) begin n++; @(negedge clk); end
            check(n == RAS_LOW, "R5 both low", n, RAS_LOW);
            n = 0;
            while (cas_n && !ras_n) begin n++; @(negedge clk); end
            check(n == TAIL, "R5 cas high tail", n, TAIL);
        end
        n = 0;
        while (ras_n && cas_n && ref_busy) begin n++; @(negedge clk); end
        check(n == PRECH, "R3 R5 precharge", n, PRECH);
    endtask

    task automatic sleep_cycle(input int hold);
        int n;
        int exp;
        while (!(!cas_n && ras_n)) @(negedge clk);
        n = 0;
        while (!cas_n && ras_n) begin n++; @(negedge clk); end
        check(n == LEAD, "R9 sleep entry lead", n, LEAD);
        n = 0;
        while (!cas_n && !ras_n) begin
            n++;
            if (n == hold) sleep_req = 1'b0;
            @(negedge clk);
        end
        exp = (hold > SELF_MIN) ? hold : SELF_MIN;
        check(n == exp, "R9 self-refresh hold", n, exp);
        acc_req = 1'b1;
        n = 0;
        while (ras_n && cas_n && !acc_grant) begin n++; @(negedge clk); end
        check(n == PRECH + 1, "R10 wake precharge to grant", n, PRECH + 1);
        check(acc_grant, "R10 grant after wake", acc_grant, 1);
        acc_req = 1'b0;
    endtask

    initial begin
        int t;
        int prev;
        int n;
        int bad;
        bit prev_ras;
        rst_n = 1'b0; cbr_mode = 1'b0; sleep_req = 1'b0; acc_req = 1'b0;
        repeat (3) @(negedge clk);
        check_idle_outs("R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle_outs("R1 after reset");

        // table walk: mixed protocols, row counter, slot spacing
        prev = 0;
        for (int i = 0; i < NVEC; i++) begin
            cbr_mode = VEC[i][3];
            while (ras_n && cas_n) @(negedge clk);
            t = cyc;
            if (i > 0) check(t - prev == SLOT, "R2 slot spacing", t - prev, SLOT);
            prev = t;
            do_refresh(VEC[i][3], int'(VEC[i][2:0]));
        end
        cbr_mode = 1'b0;

        // long access: quiet strobes, debt saturation, refresh priority
        acc_req = 1'b1;
        while (!acc_grant) @(negedge clk);
        check(acc_grant, "R8 grant", acc_grant, 1);
        bad = 0;
        for (int k = 0; k < 6 * SLOT; k++) begin
            if (!(ras_n && cas_n && !ref_busy && acc_grant)) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R8 no preemption while granted", bad, 0);
        acc_req = 1'b0;
        @(negedge clk);
        acc_req = 1'b1;
        n = 0;
        prev_ras = 1'b1;
        while (!acc_grant) begin
            if (prev_ras && !ras_n) n++;
            prev_ras = ras_n;
            @(negedge clk);
        end
        check(n >= 3, "R8 owed refresh before grant", n, 3);
        check(n <= 5, "R7 debt saturation", n, 5);

        // self-refresh: minimum residence, then request-following
        acc_req = 1'b0;
        sleep_req = 1'b1;
        sleep_cycle(1);
        @(negedge clk);
        sleep_req = 1'b1;
        sleep_cycle(70);
        @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule